// File: doc/BRIEF.md
# Link-Side Front-End Transaction Engine

This block sits at the detector end of a 32-bit half-duplex word link. Every downstream word carries a 4-bit opcode in bits [31:28]. The block decodes these words into transactions on a simple front-end bus. The bus has a request, write-enable, command flag, address, write data, read data and acknowledge, plus an end pulse. Replies travel back over the same channel once the link direction has been turned around: status words, block read data, and event data gathered during a run.

Both directions are paced by XOFF. The host holds its next word while `rx_xoff` is high, and the block holds its current upstream word while `tx_xoff` is high. Every downstream transaction ends with a host word whose opcode is 4'hF, the end-of-transaction marker. The remaining bits of that word are ignored. When a transaction needs a reply, the block turns the link only after that marker, and it leaves one idle guard cycle before each change of direction. A status reply is also held until at least `MIN_TURN` front-end clocks have passed since its bus request.

Top module: `link_fe_engine`

## Requirements
- R1: Downstream words are taken only in a cycle where `rx_valid` is high, `rx_xoff` is low and `link_dir` is 0. Upstream words are offered (`tx_valid`) only while `link_dir` is 1. After reset, `link_dir`, `tx_valid`, `fe_req`, `fe_end` and `rx_xoff` are all 0.
- R2: While `tx_valid` and `tx_xoff` are both high, the block keeps `tx_valid` high and `tx_data` unchanged in the next cycle.
- R3: A command write (opcode 4'h1) makes one front-end write with `fe_cmd`=1, `fe_addr`=0 and `fe_wdata` equal to header bits [27:0] zero-extended. It produces no upstream word.
- R4: A status read (opcode 4'h2, address in header bits [15:0]) makes one front-end read. After the marker it returns the read word and then the marker 32'hF0000000. The status word goes upstream at least `MIN_TURN` (6) cycles after `fe_req` first rose for that read.
- R5: A block write (opcode 4'h3, base address in header bits [15:0]) is followed by a length word (bits [15:0] = N) and N data words. Data word i is written to base+i. `fe_end` pulses for one cycle after the last acknowledge. No upstream word is produced.
- R6: A block read (opcode 4'h4, base address, then a length word N, then the marker) returns N words read from base+i. These are followed by an end-of-block word {4'hB, 12'h0, N} and then 32'hF0000000.
- R7: With a length of zero, a block write makes no front-end cycle and no `fe_end` pulse. A block read with a length of zero returns only 32'hF0000000.
- R8: `link_dir` changes only after an idle cycle in which no word moved in either direction. A reply begins only after the host's marker (opcode 4'hF).
- R9: Opcode 4'h5 starts a run and opcode 4'h6 ends it; neither is answered. While running, each event (`ev_valid`, with `ev_last` on its final word) goes upstream as its words, then {4'hE, 12'h0, count}, then 32'hF0000000. Outside a run, no event word is taken.
- R10: A front-end request holds `fe_addr`, `fe_we` and `fe_wdata` stable until `fe_ack`. The next word of a block moves only after that acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Host word present on the downstream path |
| rx_data | input | 32 | Downstream word |
| rx_xoff | output | 1 | Host must hold its word |
| tx_valid | output | 1 | Upstream word present |
| tx_data | output | 32 | Upstream word |
| tx_xoff | input | 1 | Block must hold its upstream word |
| link_dir | output | 1 | 0 = downstream, 1 = upstream |
| fe_req | output | 1 | Front-end transfer request |
| fe_we | output | 1 | Transfer is a write |
| fe_cmd | output | 1 | Write carries a command |
| fe_addr | output | AW | Front-end address |
| fe_wdata | output | 32 | Front-end write data |
| fe_rdata | input | 32 | Front-end read data |
| fe_ack | input | 1 | Front end completes the transfer |
| fe_end | output | 1 | One-cycle pulse after a transaction's last transfer |
| ev_valid | input | 1 | Event word present |
| ev_data | input | 32 | Event word |
| ev_last | input | 1 | Final word of the event |
| ev_ready | output | 1 | Event word taken at this edge |

## Verification
A downstream word is taken at the edge where `rx_xoff` was low. A command or block write lands on the front-end bus one cycle later and completes on the acknowledge cycle chosen by the bench's front-end model (1 to 3 cycles). The reply to a status read comes at least six cycles after the bus request. A block read reply follows the marker by a guard cycle and then two cycles per word (a read, then a send), stretched by every XOFF cycle. Because these latencies vary with the acknowledge delay and the XOFF pattern, the bench never waits a fixed number of cycles. It logs every upstream word together with the negative-edge cycle at which it was accepted, and every front-end write at its acknowledge. It then waits on those counts with a bounded timeout and compares contents, order and cycle distances after the fact.

// File: rtl/link_fe_engine.sv
`timescale 1ns/1ps
module link_fe_engine #(
  parameter int AW       = 16,
  parameter int LW       = 16,
  parameter int MIN_TURN = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [31:0]   rx_data,
  output logic          rx_xoff,
  output logic          tx_valid,
  output logic [31:0]   tx_data,
  input  logic          tx_xoff,
  output logic          link_dir,
  output logic          fe_req,
  output logic          fe_we,
  output logic          fe_cmd,
  output logic [AW-1:0] fe_addr,
  output logic [31:0]   fe_wdata,
  input  logic [31:0]   fe_rdata,
  input  logic          fe_ack,
  output logic          fe_end,
  input  logic          ev_valid,
  input  logic [31:0]   ev_data,
  input  logic          ev_last,
  output logic          ev_ready
);
  localparam int TW = $clog2(MIN_TURN + 1);
  localparam logic [3:0] OP_CMD = 4'h1, OP_STAT = 4'h2, OP_BWR = 4'h3,
                         OP_BRD = 4'h4, OP_RUN = 4'h5, OP_STOP = 4'h6,
                         OP_EOT = 4'hF, TAG_EOB = 4'hB, TAG_EOE = 4'hE;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_STAT, S_WLEN, S_WDAT, S_WFE, S_RLEN, S_EOT,
    S_GUARD, S_RFE, S_RTX, S_EOB, S_TEOT, S_EV, S_EOE
  } st_t;

  st_t           st, nxt;
  logic [3:0]    op;
  logic [AW-1:0] base;
  logic [LW-1:0] len, idx;
  logic [31:0]   wbuf, rbuf;
  logic          run;
  logic [TW-1:0] turn;

  wire rx_acc = rx_valid && !rx_xoff;
  wire tx_go  = tx_valid && !tx_xoff;
  wire last   = (idx == len - 1'b1);

  assign rx_xoff  = !(st inside {S_IDLE, S_WLEN, S_WDAT, S_RLEN, S_EOT});
  assign tx_valid = (st inside {S_RTX, S_EOB, S_TEOT, S_EOE}) || (st == S_EV && ev_valid);
  assign ev_ready = (st == S_EV) && !tx_xoff;
  assign link_dir = (st inside {S_RFE, S_RTX, S_EOB, S_TEOT, S_EV, S_EOE}) ||
                    (st == S_GUARD && nxt == S_IDLE);
  assign fe_req   = st inside {S_CMD, S_STAT, S_WFE, S_RFE};
  assign fe_we    = (st == S_CMD) || (st == S_WFE);
  assign fe_cmd   = (st == S_CMD);
  assign fe_addr  = (st == S_CMD) ? '0 : base + AW'(idx);
  assign fe_wdata = wbuf;

  always_comb begin
    case (st)
      S_RTX:   tx_data = rbuf;
      S_EOB:   tx_data = {TAG_EOB, 28'(len)};
      S_EOE:   tx_data = {TAG_EOE, 28'(idx)};
      S_TEOT:  tx_data = {OP_EOT, 28'h0};
      S_EV:    tx_data = ev_data;
      default: tx_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; nxt <= S_IDLE; op <= '0; base <= '0; len <= '0; idx <= '0;
      wbuf <= '0; rbuf <= '0; run <= 1'b0; turn <= '0; fe_end <= 1'b0;
    end else begin
      fe_end <= fe_req && fe_ack && (st == S_CMD || st == S_STAT || last);
      if (turn != TW'(MIN_TURN)) turn <= turn + 1'b1;
      case (st)
        S_IDLE:
          if (rx_acc) begin
            op   <= rx_data[31:28];
            base <= rx_data[AW-1:0];
            wbuf <= {4'h0, rx_data[27:0]};
            idx  <= '0;
            case (rx_data[31:28])
              OP_CMD:  st <= S_CMD;
              OP_STAT: begin st <= S_STAT; turn <= '0; end
              OP_BWR:  st <= S_WLEN;
              OP_BRD:  st <= S_RLEN;
              OP_RUN:  begin run <= 1'b1; st <= S_EOT; end
              OP_STOP: begin run <= 1'b0; st <= S_EOT; end
              default: ;
            endcase
          end else if (run && ev_valid) begin
            idx <= '0; nxt <= S_EV; st <= S_GUARD;
          end
        S_CMD:  if (fe_ack) st <= S_EOT;
        S_STAT: if (fe_ack) begin rbuf <= fe_rdata; st <= S_EOT; end
        S_WLEN:
          if (rx_acc) begin
            len <= rx_data[LW-1:0];
            st  <= (rx_data[LW-1:0] == '0) ? S_EOT : S_WDAT;
          end
        S_WDAT: if (rx_acc) begin wbuf <= rx_data; st <= S_WFE; end
        S_WFE:
          if (fe_ack) begin
            idx <= idx + 1'b1;
            st  <= last ? S_EOT : S_WDAT;
          end
        S_RLEN: if (rx_acc) begin len <= rx_data[LW-1:0]; st <= S_EOT; end
        S_EOT:
          if (rx_acc && rx_data[31:28] == OP_EOT) begin
            if (op == OP_STAT) begin nxt <= S_RTX; st <= S_GUARD; end
            else if (op == OP_BRD) begin
              nxt <= (len == '0) ? S_TEOT : S_RFE; st <= S_GUARD;
            end else st <= S_IDLE;
          end
        S_GUARD:
          if (!(nxt == S_RTX && turn < TW'(MIN_TURN - 1))) st <= nxt;
        S_RFE: if (fe_ack) begin rbuf <= fe_rdata; st <= S_RTX; end
        S_RTX:
          if (tx_go) begin
            if (op == OP_STAT) st <= S_TEOT;
            else begin idx <= idx + 1'b1; st <= last ? S_EOB : S_RFE; end
          end
        S_EOB:  if (tx_go) st <= S_TEOT;
        S_TEOT: if (tx_go) begin nxt <= S_IDLE; st <= S_GUARD; end
        S_EV:   if (tx_go) begin idx <= idx + 1'b1; if (ev_last) st <= S_EOE; end
        S_EOE:  if (tx_go) st <= S_TEOT;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_half_duplex_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> link_dir && rx_xoff);
  p_xoff_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_xoff |=> tx_valid && $stable(tx_data));
  p_turn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RTX && op == OP_STAT) |-> turn >= TW'(MIN_TURN));
  p_end_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fe_end |=> !fe_end);
  p_eob_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_EOB) |-> idx == len);
  p_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (link_dir != $past(link_dir)) |-> $past(!tx_valid && !rx_acc));
  p_fe_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fe_req && !fe_ack |=> fe_req && $stable(fe_addr) && $stable(fe_we) && $stable(fe_wdata));
endmodule

// File: tb/test_link_fe_engine.sv
`timescale 1ns/1ps
module test_link_fe_engine;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic        rx_valid = 0, tx_xoff = 0, fe_ack = 0, ev_valid = 0, ev_last = 0;
  logic [31:0] rx_data = 0, fe_rdata = 0, ev_data = 0;
  logic        rx_xoff, tx_valid, link_dir, fe_req, fe_we, fe_cmd, fe_end, ev_ready;
  logic [31:0] tx_data, fe_wdata;
  logic [15:0] fe_addr;

  link_fe_engine i_link_fe_engine (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .rx_xoff(rx_xoff),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_xoff(tx_xoff), .link_dir(link_dir),
    .fe_req(fe_req), .fe_we(fe_we), .fe_cmd(fe_cmd), .fe_addr(fe_addr), .fe_wdata(fe_wdata),
    .fe_rdata(fe_rdata), .fe_ack(fe_ack), .fe_end(fe_end),
    .ev_valid(ev_valid), .ev_data(ev_data), .ev_last(ev_last), .ev_ready(ev_ready));

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  localparam logic [31:0] EOT = 32'hF000_0000;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // front-end model
  int ack_dly = 1, fe_cnt = 0, n_wr = 0, n_rd = 0, n_end = 0;
  logic [31:0] wr_addr [64];
  logic [31:0] wr_data [64];
  logic        wr_cmd  [64];
  always @(negedge clk) begin
    if (fe_ack) begin
      fe_ack = 0; fe_cnt = 0;
    end else if (fe_req) begin
      fe_cnt++;
      if (fe_cnt >= ack_dly) begin
        fe_ack = 1;
        fe_rdata = 32'hC0DE_0000 | 32'(fe_addr);
        if (fe_we) begin
          if (n_wr < 64) begin
            wr_addr[n_wr] = 32'(fe_addr); wr_data[n_wr] = fe_wdata; wr_cmd[n_wr] = fe_cmd;
          end
          n_wr++;
        end else n_rd++;
      end
    end
    if (fe_end) n_end++;
  end

  // upstream XOFF pattern, changed away from the sampling edge
  bit xoff_mode = 0;
  int xcyc = 0;
  always @(posedge clk) begin
    #1;
    xcyc++;
    tx_xoff = xoff_mode && (xcyc % 3 != 0);
  end

  // link monitor
  int cyc = 0, n_up = 0, req_cyc = 0, hold_err = 0, guard_err = 0, dup_err = 0, dir_cycles = 0;
  logic [31:0] up [64];
  int up_cyc [64];
  bit prev_req = 0, prev_dir = 0, prev_busy = 0, prev_hold = 0;
  logic [31:0] prev_data = 0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_hold && !(tx_valid && tx_data == prev_data)) hold_err++;
      prev_hold = tx_valid && tx_xoff;
      prev_data = tx_data;
      if (tx_valid && !tx_xoff) begin
        if (n_up < 64) begin up[n_up] = tx_data; up_cyc[n_up] = cyc; end
        n_up++;
      end
      if (fe_req && !prev_req) req_cyc = cyc;
      prev_req = fe_req;
      if (link_dir != prev_dir && prev_busy) guard_err++;
      if (tx_valid && !link_dir) dup_err++;
      prev_busy = tx_valid || (rx_valid && !rx_xoff);
      prev_dir = link_dir;
      if (link_dir) dir_cycles++;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send(input logic [31:0] w);
    rx_data = w; rx_valid = 1;
    forever begin @(negedge clk); if (!rx_xoff) break; end
    @(posedge clk); #1;
    rx_valid = 0;
  endtask

  task automatic wait_up(input int target);
    int t = 0;
    while (n_up < target && t < 2000) begin @(negedge clk); t++; end
    idle(1);
  endtask

  task automatic send_event(input int n, input logic [31:0] seed);
    for (int i = 0; i < n; i++) begin
      ev_data = seed + 32'(i); ev_last = (i == n - 1); ev_valid = 1;
      forever begin @(negedge clk); if (ev_ready) break; end
      @(posedge clk); #1;
    end
    ev_valid = 0; ev_last = 0;
  endtask

  task automatic t_reset();
    chk(link_dir == 0, "R1 reset link_dir", 32'(link_dir), 0);
    chk(tx_valid == 0, "R1 reset tx_valid", 32'(tx_valid), 0);
    chk(fe_req == 0 && fe_end == 0, "R1 reset fe_req/fe_end", {fe_req, fe_end}, 0);
    chk(rx_xoff == 0, "R1 reset rx_xoff", 32'(rx_xoff), 0);
  endtask

  task automatic t_cmd();
    int w0 = n_wr, u0 = n_up, d0 = dir_cycles, e0 = n_end;
    ack_dly = 1;
    send(32'h10AB_CDE1); send(EOT); idle(10);
    chk(n_wr == w0 + 1, "R3 one write", n_wr - w0, 1);
    chk(wr_cmd[w0] == 1, "R3 command flag", 32'(wr_cmd[w0]), 1);
    chk(wr_data[w0] == 32'h00AB_CDE1, "R3 command payload", wr_data[w0], 32'h00AB_CDE1);
    chk(wr_addr[w0] == 0, "R3 command address", wr_addr[w0], 0);
    chk(n_up == u0 && dir_cycles == d0, "R3 no reply", n_up - u0, 0);
    chk(n_end == e0 + 1, "R3 end pulse", n_end - e0, 1);
  endtask

  task automatic t_status();
    int u0 = n_up;
    ack_dly = 2;
    send(32'h2000_0042); send(EOT); wait_up(u0 + 2); idle(4);
    chk(up[u0] == 32'hC0DE_0042, "R4 status word", up[u0], 32'hC0DE_0042);
    chk(up[u0+1] == EOT, "R4 marker after status", up[u0+1], EOT);
    chk(up_cyc[u0] - req_cyc >= 6, "R4 minimum turnaround", up_cyc[u0] - req_cyc, 6);
    chk(n_up == u0 + 2, "R4 reply length", n_up - u0, 2);
  endtask

  task automatic t_bwrite();
    int w0 = n_wr, u0 = n_up, e0 = n_end;
    ack_dly = 3;
    send(32'h3000_0100); send(32'd4);
    for (int i = 0; i < 4; i++) send(32'h1111_0000 + 32'(i));
    send(EOT); idle(10);
    chk(n_wr == w0 + 4, "R5 write count", n_wr - w0, 4);
    for (int i = 0; i < 4; i++) begin
      chk(wr_addr[w0+i] == 32'h100 + 32'(i), "R10 block write address order", wr_addr[w0+i], 32'h100 + 32'(i));
      chk(wr_data[w0+i] == 32'h1111_0000 + 32'(i) && wr_cmd[w0+i] == 0, "R5 block write data",
          wr_data[w0+i], 32'h1111_0000 + 32'(i));
    end
    chk(n_end == e0 + 1, "R5 single end pulse", n_end - e0, 1);
    chk(n_up == u0, "R5 no reply", n_up - u0, 0);
  endtask

  task automatic t_bread();
    int u0 = n_up, r0 = n_rd, h0 = hold_err, g0 = guard_err;
    ack_dly = 2; xoff_mode = 1;
    send(32'h4000_0020); send(32'd3); send(EOT); wait_up(u0 + 5);
    xoff_mode = 0; idle(5);
    for (int i = 0; i < 3; i++)
      chk(up[u0+i] == 32'hC0DE_0020 + 32'(i), "R6 read data", up[u0+i], 32'hC0DE_0020 + 32'(i));
    chk(up[u0+3] == 32'hB000_0003, "R6 end-of-block word", up[u0+3], 32'hB000_0003);
    chk(up[u0+4] == EOT, "R6 marker", up[u0+4], EOT);
    chk(n_rd == r0 + 3, "R6 read count", n_rd - r0, 3);
    chk(hold_err == h0, "R2 hold under XOFF", hold_err - h0, 0);
    chk(guard_err == g0, "R8 guard cycle", guard_err - g0, 0);
  endtask

  task automatic t_zero();
    int w0 = n_wr, e0 = n_end, u0, r0;
    send(32'h3000_0200); send(32'd0); send(EOT); idle(10);
    chk(n_wr == w0 && n_end == e0, "R7 zero write no bus cycle", n_wr - w0, 0);
    u0 = n_up; r0 = n_rd;
    send(32'h4000_0300); send(32'd0); send(EOT); wait_up(u0 + 1); idle(5);
    chk(n_up == u0 + 1 && up[u0] == EOT, "R7 zero read marker only", up[u0], EOT);
    chk(n_rd == r0, "R7 zero read no bus cycle", n_rd - r0, 0);
  endtask

  task automatic t_run();
    int u0 = n_up, u1, seen = 0, h0 = hold_err;
    send(32'h5000_0000); send(EOT); idle(5);
    chk(n_up == u0, "R9 start-run unanswered", n_up - u0, 0);
    send_event(3, 32'hEE00_0000); wait_up(u0 + 5); idle(3);
    for (int i = 0; i < 3; i++)
      chk(up[u0+i] == 32'hEE00_0000 + 32'(i), "R9 event word", up[u0+i], 32'hEE00_0000 + 32'(i));
    chk(up[u0+3] == 32'hE000_0003, "R9 end-of-event length", up[u0+3], 32'hE000_0003);
    chk(up[u0+4] == EOT, "R9 event marker", up[u0+4], EOT);
    xoff_mode = 1;
    send_event(1, 32'hEE10_0000); wait_up(u0 + 8);
    xoff_mode = 0; idle(5);
    chk(up[u0+5] == 32'hEE10_0000 && up[u0+6] == 32'hE000_0001, "R9 single-word event",
        up[u0+6], 32'hE000_0001);
    chk(hold_err == h0, "R2 event hold under XOFF", hold_err - h0, 0);
    send(32'h6000_0000); send(EOT); idle(5);
    u1 = n_up;
    ev_data = 32'hDEAD_0001; ev_last = 1; ev_valid = 1;
    repeat (30) begin @(negedge clk); if (ev_ready) seen++; end
    idle(1);
    ev_valid = 0; ev_last = 0;
    chk(n_up == u1 && seen == 0, "R9 no event after end-run", n_up - u1, 0);
    chk(dup_err == 0, "R1 upstream only while link_dir", dup_err, 0);
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1;
    idle(2);
    t_cmd();
    t_status();
    t_bwrite();
    t_bread();
    t_zero();
    t_run();
    finish_run();
  end
endmodule